// File: doc/BRIEF.md
# Vectored Interrupt Request Mapper

The mapper watches 64 level-sensitive interrupt lines and presents at most one interrupt vector request at a time on a 64-bit one-hot output. Lines 0 to 31 come from expansion slots. Each group of four consecutive slot lines shares one mapping register. Lines 32 to 63 come from on-board peripherals, and each of them has its own mapping register. Bit 31 of every mapping register enables the lines it covers. The rest of each mapping register is a fixed tag that software reads back.

Once a request is granted it stays on the output until software drops it. Software drops it through a clear register, or by disabling the mapping register whose index equals the request number. The one exception is a newly asserted slot line in an enabled group: it takes over the output at once. Whenever no request is outstanding, the block scans all lines every cycle and grants the lowest-numbered line that is both asserted and enabled. Slot lines therefore win over on-board lines.

Top module: `irq_vector_mapper`

## Requirements
- R1: After reset the request output is all zero, every enable bit is 0, and the mapping registers read back their fixed tags. The tag of slot map k is 0x7C0 + 4k and the tag of on-board map j is 0x7E0 + j.
- R2: The register address is 12 bits wide.
  - Bits 11:10 select the register type: 0 = slot map, 1 = on-board map, 2 = slot clear, 3 = on-board clear.
  - The slot map index is in bits 5:3. The on-board map and on-board clear index is in bits 7:3. The slot clear index is in bits 7:5.
  - A map read returns {enable, 31-bit tag}. A write changes only the enable bit, which is taken from write data bit 31.
- R3: Only accesses with address bit 2 set have any effect. A write with bit 2 clear changes nothing. A read with bit 2 clear, or any read of a clear register, returns zero.
- R4: Slot line i is enabled by slot map i/4. On-board line 32+j is enabled by on-board map j. An asserted line whose map is disabled is never granted.
- R5: With no request outstanding, the lowest-numbered line that is asserted and enabled is granted on the next clock edge. The output is the one-hot code of the granted line number, or zero when no request is outstanding.
- R6: An outstanding request stays unchanged in the following cases:
  - while inputs change, including deassertion of the granted line itself;
  - while on-board lines assert;
  - across map writes that do not drop it.
- R7: When a slot line rises while its group is enabled, that line replaces the outstanding request on the next edge. If several slot lines rise together, the lowest-numbered one wins.
- R8: A map write with bit 31 = 0 drops the outstanding request in two cases: a slot map write to index k when the request equals k, and an on-board map write to index j when the request equals 32+j. Every map write is followed by a fresh scan.
- R9: A slot clear at index k drops the request when the request divided by 4 equals k. An on-board clear at index k drops the request when it equals 32+k. After a drop, the block rescans in the same cycle.
- R10: A disabling map write whose index does not match the outstanding request leaves that request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Level interrupt lines; 0–31 slot, 32–63 on-board |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_vec | output | 64 | One-hot outstanding request |

## Verification
The bench targets the stickiness of a grant:
- A design that dropped a request on input deassertion would show zero while the bench expects the old line.
- A design that let an on-board line preempt would switch vectors.

It targets the two drop rules:
- The slot clear compares the request divided by four. A bit-slice error would leave the request stuck, or clear the wrong group.
- A disabling map write drops only a request with a matching index. Getting this wrong either keeps the request or drops it spuriously.

The low-word rule is tested with writes that have address bit 2 clear. A design that ignored bit 2 would turn on an enable. Long random runs compare every cycle against a bench model, so they also expose any misordered scan priority between slot and on-board lines.

// File: rtl/irq_vector_mapper.sv
module irq_vector_mapper #(
  parameter int SLOT_LINES = 32,
  parameter int GRP_SIZE   = 4,
  parameter int ONB_LINES  = 32,
  parameter int AW         = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SLOT_LINES+ONB_LINES-1:0] irq_in,
  input  logic                            reg_we,
  input  logic [AW-1:0]                   reg_addr,
  input  logic [31:0]                     reg_wdata,
  output logic [31:0]                     reg_rdata,
  output logic [SLOT_LINES+ONB_LINES-1:0] req_vec
);
  localparam int N    = SLOT_LINES + ONB_LINES;
  localparam int NGRP = SLOT_LINES / GRP_SIZE;
  localparam int GW   = $clog2(NGRP);
  localparam int OW   = $clog2(ONB_LINES);
  localparam int GSH  = $clog2(GRP_SIZE);
  localparam int IW   = $clog2(N) + 1;
  localparam logic [IW-1:0] NONE    = IW'(N);
  localparam logic [30:0]   MAP_TAG = 31'h7C0;

  logic [NGRP-1:0]      en_slot, en_slot_n;
  logic [ONB_LINES-1:0] en_onb, en_onb_n;
  logic [N-1:0]         lvl, line_en_n, rise, pend;
  logic [IW-1:0]        req_q, req_a, req_d;

  function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
    lowest = NONE;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) lowest = IW'(i);
  endfunction

  wire          hi       = reg_addr[2];
  wire [1:0]    rgn      = reg_addr[AW-1:AW-2];
  wire [GW-1:0] slot_idx = reg_addr[3 +: GW];
  wire [GW-1:0] sclr_idx = reg_addr[3+GSH +: GW];
  wire [OW-1:0] onb_idx  = reg_addr[3 +: OW];
  wire          en_bit   = reg_wdata[31];

  wire wr_smap = reg_we && hi && rgn == 2'd0;
  wire wr_omap = reg_we && hi && rgn == 2'd1;
  wire wr_sclr = reg_we && hi && rgn == 2'd2;
  wire wr_oclr = reg_we && hi && rgn == 2'd3;

  wire unused_bits = ^{reg_wdata[30:0], reg_addr[1:0], reg_addr[AW-3:8]};

  always_comb begin
    en_slot_n = en_slot;
    en_onb_n  = en_onb;
    if (wr_smap) en_slot_n[slot_idx] = en_bit;
    if (wr_omap) en_onb_n[onb_idx]   = en_bit;
  end

  genvar gi;
  generate
    for (gi = 0; gi < SLOT_LINES; gi++) begin : g_slot_en
      assign line_en_n[gi] = en_slot_n[gi / GRP_SIZE];
    end
    for (gi = 0; gi < ONB_LINES; gi++) begin : g_onb_en
      assign line_en_n[SLOT_LINES + gi] = en_onb_n[gi];
    end
    for (gi = 0; gi < N; gi++) begin : g_out
      assign req_vec[gi] = (req_q == IW'(gi));
    end
  endgenerate

  wire onb_hit  = req_q == IW'(SLOT_LINES) + IW'(onb_idx);
  wire drop     = (wr_smap && !en_bit && req_q == IW'(slot_idx))
               || (wr_omap && !en_bit && onb_hit)
               || (wr_sclr && (req_q >> GSH) == IW'(sclr_idx))
               || (wr_oclr && onb_hit);

  assign rise = irq_in & ~lvl;
  assign pend = irq_in & line_en_n;
  wire [SLOT_LINES-1:0] slot_pre = rise[SLOT_LINES-1:0] & line_en_n[SLOT_LINES-1:0];

  always_comb begin
    req_a = drop ? NONE : req_q;
    if (|slot_pre)
      req_d = lowest({{ONB_LINES{1'b0}}, slot_pre});
    else if (req_a == NONE)
      req_d = lowest(pend);
    else
      req_d = req_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_slot <= '0;
      en_onb  <= '0;
      lvl     <= '0;
      req_q   <= NONE;
    end else begin
      en_slot <= en_slot_n;
      en_onb  <= en_onb_n;
      lvl     <= irq_in;
      req_q   <= req_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hi) begin
      case (rgn)
        2'd0: reg_rdata = {en_slot[slot_idx], MAP_TAG + 31'(slot_idx) * 31'(GRP_SIZE)};
        2'd1: reg_rdata = {en_onb[onb_idx], MAP_TAG + 31'(SLOT_LINES) + 31'(onb_idx)};
        default: reg_rdata = '0;
      endcase
    end
  end

  AST_ONEHOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_vec)); // R5
  AST_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == NONE && !reg_we && |(irq_in & line_en_n)) |=> req_q != NONE); // R5
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != NONE && !reg_we && slot_pre == '0) |=> $stable(req_q)); // R6
  AST_SLOT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_pre) |=> req_q < IW'(SLOT_LINES)); // R7
  AST_LOW_WORD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr[2]) |=> ($stable(en_slot) && $stable(en_onb))); // R3
  AST_LOW_WORD_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr[2] |-> reg_rdata == 32'd0); // R3
endmodule

// File: tb/irq_vector_mapper_tb.sv
`timescale 1ns/1ps
module irq_vector_mapper_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_in = '0;
  logic        reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] req_vec;

  int checks = 0;
  int failures = 0;

  logic [7:0]  m_en_s = '0;
  logic [31:0] m_en_o = '0;
  logic [63:0] m_lvl = '0;
  int          m_req = 64;
  logic [63:0] lines = '0;

  always #4 clk = ~clk;

  irq_vector_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_vec(req_vec));

  function automatic logic [11:0] a_smap(int k); return 12'h004 | 12'(k << 3); endfunction
  function automatic logic [11:0] a_omap(int k); return 12'h404 | 12'(k << 3); endfunction
  function automatic logic [11:0] a_sclr(int k); return 12'h804 | 12'(k << 5); endfunction
  function automatic logic [11:0] a_oclr(int k); return 12'hC04 | 12'(k << 3); endfunction

  function automatic logic [63:0] onehot(int r);
    return (r >= 64) ? 64'd0 : (64'd1 << r);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(logic we, logic [11:0] a, logic [31:0] d, logic [63:0] irq);
    logic [63:0] en;
    int pick;
    bit drop;
    int gi, ci, oi;
    gi = int'(a[5:3]); ci = int'(a[7:5]); oi = int'(a[7:3]);
    drop = 0;
    if (we && a[2]) begin
      case (a[11:10])
        2'd0: begin m_en_s[gi] = d[31]; if (!d[31] && m_req == gi) drop = 1; end
        2'd1: begin m_en_o[oi] = d[31]; if (!d[31] && m_req == 32 + oi) drop = 1; end
        2'd2: if (m_req / 4 == ci) drop = 1;
        default: if (m_req == 32 + oi) drop = 1;
      endcase
    end
    if (drop) m_req = 64;
    for (int i = 0; i < 64; i++) en[i] = (i < 32) ? m_en_s[i / 4] : m_en_o[i - 32];
    pick = 64;
    for (int i = 31; i >= 0; i--) if (irq[i] && !m_lvl[i] && en[i]) pick = i;
    if (pick < 64) m_req = pick;
    else if (m_req == 64) begin
      for (int i = 63; i >= 0; i--) if (irq[i] && en[i]) pick = i;
      m_req = pick;
    end
    m_lvl = irq;
  endtask

  task automatic cyc(logic we, logic [11:0] a, logic [31:0] d, logic [63:0] irq);
    reg_we = we; reg_addr = a; reg_wdata = d; irq_in = irq;
    @(posedge clk);
    model_step(we, a, d, irq);
    @(negedge clk);
    reg_we = 0;
    check("R5 model", req_vec, onehot(m_req));
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    reg_we = 0; reg_addr = a;
    #1;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    int r, k;
    logic [31:0] e;
    seed = $urandom(32'h1234_5678);
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R1 reset out", req_vec, 64'd0);
    rd(a_smap(3), 32'h0000_07CC, "R1 slot tag");
    rd(a_omap(5), 32'h0000_07E5, "R1 onboard tag");

    cyc(1, 12'h000, 32'h8000_0000, lines);
    rd(a_smap(0), 32'h0000_07C0, "R3 low write ignored");
    rd(12'h000, 32'h0, "R3 low read zero");
    cyc(1, a_smap(1), 32'hFFFF_FFFF, lines);
    rd(a_smap(1), 32'h8000_07C4, "R2 only bit31 writable");

    lines = 64'd1 << 2; cyc(0, 0, 0, lines);
    check("R4 disabled group", req_vec, 64'd0);
    lines |= 64'd1 << 5; cyc(0, 0, 0, lines);
    check("R4 enabled group", req_vec, 64'd1 << 5);
    cyc(1, a_omap(0), 32'h8000_0000, lines);
    check("R6 map write holds", req_vec, 64'd1 << 5);
    lines |= 64'd1 << 32; cyc(0, 0, 0, lines);
    check("R6 onboard no replace", req_vec, 64'd1 << 5);
    lines &= ~(64'd1 << 5); cyc(0, 0, 0, lines);
    check("R6 deassert holds", req_vec, 64'd1 << 5);
    cyc(1, a_sclr(1), 0, lines);
    check("R9 slot clear rescan", req_vec, 64'd1 << 32);
    lines &= ~(64'd1 << 32); cyc(0, 0, 0, lines);
    cyc(1, a_oclr(0), 0, lines);
    check("R9 onboard clear", req_vec, 64'd0);
    cyc(1, a_omap(3), 32'h8000_0000, lines);
    lines |= 64'd1 << 35; cyc(0, 0, 0, lines);
    check("R5 onboard grant", req_vec, 64'd1 << 35);
    lines |= 64'd1 << 6; cyc(0, 0, 0, lines);
    check("R7 slot preempts", req_vec, 64'd1 << 6);
    lines &= ~(64'd1 << 6); cyc(0, 0, 0, lines);
    cyc(1, a_sclr(1), 0, lines);
    check("R9 clear then lowest", req_vec, 64'd1 << 35);
    cyc(1, a_omap(4), 0, lines);
    check("R10 other onboard map", req_vec, 64'd1 << 35);
    cyc(1, a_smap(1), 0, lines);
    check("R10 slot map mismatch", req_vec, 64'd1 << 35);
    cyc(1, a_omap(3), 0, lines);
    check("R8 matching disable drops", req_vec, 64'd0);
    cyc(1, a_omap(3), 32'h8000_0000, lines);
    check("R8 check after write", req_vec, 64'd1 << 35);

    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [11:0] a;
      if ($urandom % 3 == 0) lines ^= 64'd1 << ($urandom % 64);
      we = ($urandom % 4 == 0);
      r = $urandom % 4;
      k = $urandom % 32;
      case (r)
        0: a = a_smap(k % 8);
        1: a = a_omap(k);
        2: a = a_sclr(k % 8);
        default: a = a_oclr(k);
      endcase
      if ($urandom % 5 == 0) a[2] = 1'b0;
      cyc(we, a, $urandom, lines);
      if (n % 8 == 0) begin
        k = $urandom % 32;
        e = {m_en_o[k], 31'h7E0 + 31'(k)};
        rd(a_omap(k), e, "R2 random onboard read");
        k = k % 8;
        e = {m_en_s[k], 31'h7C0 + 31'(4 * k)};
        rd(a_smap(k), e, "R2 random slot read");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule